// File: doc/BRIEF.md
# External Interrupt Pin Controller

This block takes up to eight asynchronous interrupt request pins from outside the chip and turns them into clean, per-pin interrupt outputs for a processor's interrupt controller. Each pin is brought into the clock domain and then judged against a detection mode chosen per pin: falling edge, rising edge, both edges, low level or high level. A qualifying event latches into a pending bit, and the pending bit raises the pin's output only when the pin is unmasked and its priority field is non-zero. A single combined output, the OR of all per-pin outputs, serves systems that wire every pin to one shared request line.

Software reaches the block through a simple synchronous register port with a write strobe, a 3-bit register select, 32-bit write data and combinational read data. Select 0 is the detection-mode register, 1 the priority register, 2 the pending register, 3 the write-only mask-set register and 4 the write-only mask-clear register. Every register orders its per-pin fields with pin 0 in the most significant position. The pending, mask-set and mask-clear registers hold one bit per pin and can be built 8 or 32 bits wide.

Top module: `extirq_ctrl`

## Requirements
- R1: After reset, the mode, priority and pending registers read 0, every pin is masked and irq_o and irq_any_o are low; a pending pin stays silent until it is unmasked.
- R2: The mode register holds one field per pin, 4 bits wide by default or 2 bits as an option; pin n's field has its least significant bit at 32 - (n+1)*width, and a written value reads back unchanged in the implemented fields.
- R3: The priority register holds a 4-bit field per pin placed the same way as the mode fields (pin 0 at bits 31:28); it reads back as written, and a pin whose field is 0 never drives its output, while a non-zero field lets it.
- R4: Mode code 1 sets pending on a low-to-high transition and code 0 on a high-to-low one, once per transition; a pin change made before a clock edge shows on irq_o after the third rising edge, not after the second.
- R5: Mode code 3 (high) and code 2 (low) set pending on every cycle the pin is at the active level, so clearing the pending bit takes effect only once the pin has gone inactive.
- R6: Mode code 4 sets pending on both the rising and the falling transition of the pin.
- R7: Mode codes 5 and above never set a pending bit, whatever the pin does.
- R8: In the pending register pin n is bit (width-1-n), so pin 0 is bit 7 in the 8-bit form; writing 0 to a bit clears it, writing 1 leaves it as it is, and unused upper bits read 0.
- R9: When an event and a software clear hit the same pending bit on the same edge, the bit ends up set.
- R10: Writing 1 to a pin's bit (same placement as the pending register) of the mask-set register masks it, writing 1 in the mask-clear register unmasks it, writing 0 to either changes nothing, and both read as 0.
- R11: irq_o[n] is high exactly when pin n is pending, unmasked and has a non-zero priority field, and irq_any_o is the OR of all irq_o bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released on the clock inside the block |
| pins_i | input | NUM_PINS | Asynchronous external request pins |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register select: 0 mode, 1 priority, 2 pending, 3 mask-set, 4 mask-clear |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Combinational read data of the selected register |
| irq_o | output | NUM_PINS | Per-pin interrupt outputs |
| irq_any_o | output | 1 | OR of all per-pin outputs for a shared line |

## Verification
A wrong pending bit is visible at once, in the same cycle, both on irq_o for an unmasked pin with a live priority and in the pending register readback, so a reference model compares irq_o every cycle while pins toggle at random and modes, priorities and masks are rewritten. A detector that fires in the wrong mode or a synchroniser with the wrong depth shows up as an output one cycle early or late against the three-edge latency, which the directed cases sample edge by edge. A lost event in the clear-versus-set race or a stale mask bit persists until software acts, so it is read back right after the write that provokes it.

// File: rtl/extirq_pkg.sv
package extirq_pkg;

  localparam int REG_W  = 32;
  localparam int ADDR_W = 3;
  localparam int PRIO_W = 4;

  // register select codes
  localparam logic [ADDR_W-1:0] SEL_MODE = 3'd0;
  localparam logic [ADDR_W-1:0] SEL_PRIO = 3'd1;
  localparam logic [ADDR_W-1:0] SEL_PEND = 3'd2;
  localparam logic [ADDR_W-1:0] SEL_MSET = 3'd3;
  localparam logic [ADDR_W-1:0] SEL_MCLR = 3'd4;

  // detection mode codes
  localparam logic [3:0] MODE_FALL = 4'd0;
  localparam logic [3:0] MODE_RISE = 4'd1;
  localparam logic [3:0] MODE_LOW  = 4'd2;
  localparam logic [3:0] MODE_HIGH = 4'd3;
  localparam logic [3:0] MODE_BOTH = 4'd4;

  // lsb position of a per-pin field packed from the top of a 32-bit word
  function automatic int field_lsb(input int pin, input int w);
    return REG_W - (pin + 1) * w;
  endfunction

  // bits occupied by the fields of the first npins pins
  function automatic logic [REG_W-1:0] field_span(input int npins, input int w);
    logic [REG_W-1:0] m;
    m = '0;
    for (int p = 0; p < npins; p++) begin
      for (int b = 0; b < w; b++) begin
        m[field_lsb(p, w) + b] = 1'b1;
      end
    end
    return m;
  endfunction

endpackage

// File: rtl/extirq_rst_sync.sv
module extirq_rst_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [1:0] stage_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_q <= 2'b00;
    end else begin
      stage_q <= {stage_q[0], 1'b1};
    end
  end

  assign rst_no = stage_q[1];
endmodule

// File: rtl/extirq_sync.sv
module extirq_sync #(
  parameter int NUM_PINS = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_PINS-1:0] pins_i,
  output logic [NUM_PINS-1:0] lvl_o,
  output logic [NUM_PINS-1:0] prev_o
);
  logic [NUM_PINS-1:0] meta_q, lvl_q, prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      lvl_q  <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= pins_i;
      lvl_q  <= meta_q;
      prev_q <= lvl_q;
    end
  end

  assign lvl_o  = lvl_q;
  assign prev_o = prev_q;
endmodule

// File: rtl/extirq_detect.sv
module extirq_detect #(
  parameter int SENSE_W = 4
) (
  input  logic [SENSE_W-1:0] mode_i,
  input  logic               cur_i,
  input  logic               prev_i,
  output logic               evt_o
);
  import extirq_pkg::*;

  logic [3:0] mode_ext;
  assign mode_ext = 4'(mode_i);

  always_comb begin
    unique case (mode_ext)
      MODE_FALL: evt_o = prev_i & ~cur_i;
      MODE_RISE: evt_o = ~prev_i & cur_i;
      MODE_LOW:  evt_o = ~cur_i;
      MODE_HIGH: evt_o = cur_i;
      MODE_BOTH: evt_o = prev_i ^ cur_i;
      default:   evt_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/extirq_regs.sv
module extirq_regs #(
  parameter int NUM_PINS = 8,
  parameter int SENSE_W  = 4,
  parameter int SRC_W    = 8
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          we_i,
  input  logic [extirq_pkg::ADDR_W-1:0] addr_i,
  input  logic [extirq_pkg::REG_W-1:0]  wdata_i,
  output logic [extirq_pkg::REG_W-1:0]  rdata_o,
  input  logic [NUM_PINS-1:0]           evt_i,
  output logic [extirq_pkg::REG_W-1:0]  mode_o,
  output logic [NUM_PINS-1:0]           pend_o,
  output logic [NUM_PINS-1:0]           mask_o,
  output logic [NUM_PINS-1:0]           prio_en_o
);
  import extirq_pkg::*;

  localparam logic [REG_W-1:0] MODE_SPAN = field_span(NUM_PINS, SENSE_W);
  localparam logic [REG_W-1:0] PRIO_SPAN = field_span(NUM_PINS, PRIO_W);

  logic [REG_W-1:0]    mode_q, mode_d, prio_q, prio_d;
  logic [NUM_PINS-1:0] pend_q, pend_d, mask_q, mask_d;
  logic [NUM_PINS-1:0] wbit, pend_clr, mask_set, mask_clr;
  logic                mode_we, prio_we, pend_we, mset_we, mclr_we;
  logic                pend_en, mask_en;

  assign mode_we = we_i && (addr_i == SEL_MODE);
  assign prio_we = we_i && (addr_i == SEL_PRIO);
  assign pend_we = we_i && (addr_i == SEL_PEND);
  assign mset_we = we_i && (addr_i == SEL_MSET);
  assign mclr_we = we_i && (addr_i == SEL_MCLR);

  // per-pin bit of the write word, pin 0 at the top bit of the SRC_W form
  always_comb begin
    for (int n = 0; n < NUM_PINS; n++) begin
      wbit[n] = wdata_i[SRC_W-1-n];
    end
  end

  assign pend_clr = {NUM_PINS{pend_we}} & ~wbit;
  assign mask_set = {NUM_PINS{mset_we}} & wbit;
  assign mask_clr = {NUM_PINS{mclr_we}} & wbit;

  // next state
  always_comb begin
    mode_d  = wdata_i & MODE_SPAN;
    prio_d  = wdata_i & PRIO_SPAN;
    pend_d  = (pend_q & ~pend_clr) | evt_i;   // a new event beats a clear
    mask_d  = (mask_q | mask_set) & ~mask_clr;
    pend_en = pend_we | (|evt_i);
    mask_en = mset_we | mclr_we;
  end

  // state
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= '0;
      prio_q <= '0;
      pend_q <= '0;
      mask_q <= '1;
    end else begin
      if (mode_we) mode_q <= mode_d;
      if (prio_we) prio_q <= prio_d;
      if (pend_en) pend_q <= pend_d;
      if (mask_en) mask_q <= mask_d;
    end
  end

  // priority gate per pin
  always_comb begin
    for (int n = 0; n < NUM_PINS; n++) begin
      prio_en_o[n] = |prio_q[field_lsb(n, PRIO_W) +: PRIO_W];
    end
  end

  // read path
  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      SEL_MODE: rdata_o = mode_q;
      SEL_PRIO: rdata_o = prio_q;
      SEL_PEND: begin
        for (int n = 0; n < NUM_PINS; n++) begin
          rdata_o[SRC_W-1-n] = pend_q[n];
        end
      end
      default:  rdata_o = '0;
    endcase
  end

  assign mode_o = mode_q;
  assign pend_o = pend_q;
  assign mask_o = mask_q;
endmodule

// File: rtl/extirq_ctrl.sv
module extirq_ctrl #(
  parameter int NUM_PINS = 8,
  parameter int SENSE_W  = 4,
  parameter int SRC_W    = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_PINS-1:0] pins_i,
  input  logic                reg_we_i,
  input  logic [2:0]          reg_addr_i,
  input  logic [31:0]         reg_wdata_i,
  output logic [31:0]         reg_rdata_o,
  output logic [NUM_PINS-1:0] irq_o,
  output logic                irq_any_o
);
  import extirq_pkg::*;

  logic                rst_n_sync;
  logic [NUM_PINS-1:0] lvl, prev, evt, pend_q, mask_q, prio_en;
  logic [REG_W-1:0]    mode_q;

  extirq_rst_sync u_rst (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_n_sync)
  );

  extirq_sync #(.NUM_PINS(NUM_PINS)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_n_sync),
    .pins_i (pins_i),
    .lvl_o  (lvl),
    .prev_o (prev)
  );

  for (genvar n = 0; n < NUM_PINS; n++) begin : g_det
    extirq_detect #(.SENSE_W(SENSE_W)) u_det (
      .mode_i (mode_q[field_lsb(n, SENSE_W) +: SENSE_W]),
      .cur_i  (lvl[n]),
      .prev_i (prev[n]),
      .evt_o  (evt[n])
    );
  end

  extirq_regs #(
    .NUM_PINS (NUM_PINS),
    .SENSE_W  (SENSE_W),
    .SRC_W    (SRC_W)
  ) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_n_sync),
    .we_i      (reg_we_i),
    .addr_i    (reg_addr_i),
    .wdata_i   (reg_wdata_i),
    .rdata_o   (reg_rdata_o),
    .evt_i     (evt),
    .mode_o    (mode_q),
    .pend_o    (pend_q),
    .mask_o    (mask_q),
    .prio_en_o (prio_en)
  );

  assign irq_o     = pend_q & ~mask_q & prio_en;
  assign irq_any_o = |irq_o;
endmodule

// File: rtl/extirq_ctrl_chk.sv
module extirq_ctrl_chk #(
  parameter int NUM_PINS = 8,
  parameter int SENSE_W  = 4,
  parameter int SRC_W    = 8
) (
  input logic                clk_i,
  input logic                rst_n_sync,
  input logic                reg_we_i,
  input logic [2:0]          reg_addr_i,
  input logic [31:0]         reg_wdata_i,
  input logic [NUM_PINS-1:0] evt,
  input logic [NUM_PINS-1:0] pend_q,
  input logic [NUM_PINS-1:0] mask_q,
  input logic [31:0]         mode_q,
  input logic [NUM_PINS-1:0] irq_o,
  input logic                irq_any_o
);
  import extirq_pkg::*;

  for (genvar n = 0; n < NUM_PINS; n++) begin : g_pin
    logic [3:0] mode_n;
    assign mode_n = 4'(mode_q[field_lsb(n, SENSE_W) +: SENSE_W]);

    assert_pend_from_event_R4: assert property (@(posedge clk_i) disable iff (!rst_n_sync)
      $rose(pend_q[n]) |-> $past(evt[n]));

    assert_event_beats_clear_R9: assert property (@(posedge clk_i) disable iff (!rst_n_sync)
      evt[n] |=> pend_q[n]);

    assert_bad_mode_silent_R7: assert property (@(posedge clk_i) disable iff (!rst_n_sync)
      (mode_n > MODE_BOTH) |-> !evt[n]);

    assert_mask_set_R10: assert property (@(posedge clk_i) disable iff (!rst_n_sync)
      (reg_we_i && reg_addr_i == SEL_MSET && reg_wdata_i[SRC_W-1-n]) |=> mask_q[n]);

    assert_mask_clear_R10: assert property (@(posedge clk_i) disable iff (!rst_n_sync)
      (reg_we_i && reg_addr_i == SEL_MCLR && reg_wdata_i[SRC_W-1-n]) |=> !mask_q[n]);

    assert_output_gated_R11: assert property (@(posedge clk_i) disable iff (!rst_n_sync)
      irq_o[n] |-> (pend_q[n] && !mask_q[n] && irq_any_o));
  end
endmodule

bind extirq_ctrl extirq_ctrl_chk #(
  .NUM_PINS (NUM_PINS),
  .SENSE_W  (SENSE_W),
  .SRC_W    (SRC_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_n_sync  (rst_n_sync),
  .reg_we_i    (reg_we_i),
  .reg_addr_i  (reg_addr_i),
  .reg_wdata_i (reg_wdata_i),
  .evt         (evt),
  .pend_q      (pend_q),
  .mask_q      (mask_q),
  .mode_q      (mode_q),
  .irq_o       (irq_o),
  .irq_any_o   (irq_any_o)
);

// File: tb/extirq_ctrl_bench.sv
module extirq_ctrl_bench;
  localparam int N  = 8;
  localparam int SW = 4;
  localparam int SRCW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  pins = '0;
  logic          we = 1'b0;
  logic [2:0]    addr = 3'd0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic [N-1:0]  irq;
  logic          irq_any;

  int checks = 0;
  int fails  = 0;
  bit cmp_on = 1'b0;
  bit done   = 1'b0;

  always #10 clk = ~clk;   // 50 MHz

  extirq_ctrl #(.NUM_PINS(N), .SENSE_W(SW), .SRC_W(SRCW)) u_extirq_ctrl (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .pins_i      (pins),
    .reg_we_i    (we),
    .reg_addr_i  (addr),
    .reg_wdata_i (wdata),
    .reg_rdata_o (rdata),
    .irq_o       (irq),
    .irq_any_o   (irq_any)
  );

  // ---------------- reference model built from the requirements
  logic [N-1:0] m_s1, m_s2, m_prev, m_pend, m_mask;
  logic [31:0]  m_mode, m_prio;

  function automatic logic fires(input logic [3:0] code, input logic cur, input logic prv);
    case (code)
      4'd0: return prv & ~cur;
      4'd1: return ~prv & cur;
      4'd2: return ~cur;
      4'd3: return cur;
      4'd4: return cur ^ prv;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [N-1:0] expect_irq();
    logic [N-1:0] r;
    for (int n = 0; n < N; n++) begin
      r[n] = m_pend[n] & ~m_mask[n] & (m_prio[32-(n+1)*4 +: 4] != 4'd0);
    end
    return r;
  endfunction

  function automatic logic [31:0] expect_pend_word();
    logic [31:0] r;
    r = '0;
    for (int n = 0; n < N; n++) r[SRCW-1-n] = m_pend[n];
    return r;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 <= '0; m_s2 <= '0; m_prev <= '0; m_pend <= '0;
      m_mask <= '1; m_mode <= '0; m_prio <= '0;
    end else begin
      logic [N-1:0] ev, clr, wb;
      for (int n = 0; n < N; n++) begin
        ev[n] = fires(m_mode[32-(n+1)*SW +: SW], m_s2[n], m_prev[n]);
        wb[n] = wdata[SRCW-1-n];
      end
      clr = (we && addr == 3'd2) ? ~wb : '0;
      m_s1 <= pins; m_s2 <= m_s1; m_prev <= m_s2;
      m_pend <= (m_pend & ~clr) | ev;
      if (we && addr == 3'd0) m_mode <= wdata;
      if (we && addr == 3'd1) m_prio <= wdata;
      if (we && addr == 3'd3) m_mask <= m_mask | wb;
      if (we && addr == 3'd4) m_mask <= m_mask & ~wb;
    end
  end

  // ---------------- checking helpers
  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // continuous output comparison against the model
  always @(negedge clk) begin
    if (cmp_on && rst_n) begin
      check("R11 irq_o", 32'(irq), 32'(expect_irq()));
      check("R11 irq_any_o", 32'(irq_any), 32'(|expect_irq()));
    end
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    @(negedge clk); addr = a; #1; v = rdata;
  endtask

  task automatic idle(input int c);
    repeat (c) @(negedge clk);
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  // watchdog
  initial begin
    #(20 * 150000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual running expected finished");
      report();
    end
  end

  initial begin
    logic [31:0] v;
    idle(3);
    rst_n = 1'b1;
    idle(5);
    cmp_on = 1'b1;

    // R1 reset state
    rd(3'd0, v); check("R1 mode reset", v, 32'h0);
    rd(3'd1, v); check("R1 prio reset", v, 32'h0);
    rd(3'd2, v); check("R1 pend reset", v, 32'h0);
    check("R1 irq reset", 32'(irq), 32'h0);

    // R3 / R2 readback, R8 bit placement, R1 masked after reset
    wr(3'd1, 32'hFFFF_FFFF);
    rd(3'd1, v); check("R3 prio readback", v, 32'hFFFF_FFFF);
    wr(3'd0, 32'h3000_0000);             // pin 0 high level
    rd(3'd0, v); check("R2 mode readback", v, 32'h3000_0000);
    pins[0] = 1'b1;
    idle(4);
    rd(3'd2, v); check("R8 pin0 is bit 7", v, 32'h80);
    check("R1 pending but masked", 32'(irq), 32'h0);

    // R10 mask set/clear
    wr(3'd3, 32'h0);                     // zero: no effect
    wr(3'd4, 32'h0);
    check("R10 zero write no effect", 32'(irq), 32'h0);
    wr(3'd4, 32'h80);
    check("R10 unmask pin0", 32'(irq), 32'h01);
    rd(3'd3, v); check("R10 mask-set reads 0", v, 32'h0);
    rd(3'd4, v); check("R10 mask-clear reads 0", v, 32'h0);

    // R5 level re-sets after a clear
    wr(3'd2, 32'h0);
    rd(3'd2, v); check("R5 level holds pending", v, 32'h80);

    // R3 zero priority blocks the pin
    wr(3'd1, 32'h0FFF_FFFF);
    check("R3 prio zero blocks", 32'(irq), 32'h0);
    wr(3'd1, 32'hFFFF_FFFF);
    check("R3 prio nonzero passes", 32'(irq), 32'h01);

    // R5 clear sticks once inactive; R8 write 1 keeps
    pins[0] = 1'b0;
    idle(4);
    wr(3'd2, 32'hFF);
    rd(3'd2, v); check("R8 write one keeps", v, 32'h80);
    wr(3'd2, 32'h7F);
    rd(3'd2, v); check("R5 clear after inactive", v, 32'h0);

    // R4 rising edge latency and single event
    wr(3'd0, 32'h0100_0000);             // pin 1 rising, others falling
    wr(3'd4, 32'h40);
    @(negedge clk); pins[1] = 1'b1;
    @(posedge clk); @(posedge clk); @(negedge clk);
    check("R4 not after second edge", 32'(irq[1]), 32'h0);
    @(posedge clk); @(negedge clk);
    check("R4 after third edge", 32'(irq[1]), 32'h1);
    wr(3'd2, 32'h0);
    idle(3);
    rd(3'd2, v); check("R4 one event per edge", v, 32'h0);
    // falling edge on pin 1
    wr(3'd0, 32'h0000_0000);
    pins[1] = 1'b0;
    idle(4);
    rd(3'd2, v); check("R4 falling edge", v, 32'h40);
    wr(3'd2, 32'h0);

    // R6 both edges on pin 2
    wr(3'd0, 32'h0040_0000);
    wr(3'd4, 32'h20);
    pins[2] = 1'b1; idle(4);
    rd(3'd2, v); check("R6 rising", v, 32'h20);
    wr(3'd2, 32'h0);
    pins[2] = 1'b0; idle(4);
    rd(3'd2, v); check("R6 falling", v, 32'h20);
    wr(3'd2, 32'h0);

    // R7 invalid codes on pins 3 and 4
    wr(3'd0, 32'h0005_F000);
    for (int k = 0; k < 6; k++) begin
      pins[3] = ~pins[3]; pins[4] = ~pins[4]; idle(3);
    end
    rd(3'd2, v); check("R7 invalid codes silent", v, 32'h0);
    pins[3] = 1'b0; pins[4] = 1'b0;
    wr(3'd0, 32'h0);
    idle(4);
    wr(3'd2, 32'h0);

    // R9 event and clear on the same edge
    wr(3'd0, 32'h0100_0000);
    @(negedge clk); pins[1] = 1'b1;
    @(posedge clk); @(posedge clk);
    wr(3'd2, 32'h0);                     // commits on the third edge
    rd(3'd2, v); check("R9 set beats clear", v, 32'h40);

    // R11 combined output
    wr(3'd4, 32'hFF);
    wr(3'd2, 32'h0);
    check("R11 any low", 32'(irq_any), 32'h0);
    pins[1] = 1'b0; idle(4);
    pins[1] = 1'b1; idle(4);
    check("R11 only pin1", 32'(irq), 32'h02);
    check("R11 any high", 32'(irq_any), 32'h1);

    // random phase checked against the model
    void'($urandom(32'h1357));
    for (int it = 0; it < 3000; it++) begin
      @(negedge clk);
      pins = N'($urandom);
      we = 1'b0;
      if (($urandom % 5) == 0) begin
        logic [31:0] d;
        we = 1'b1;
        addr = 3'($urandom % 5);
        if (addr == 3'd0) begin
          d = '0;
          for (int f = 0; f < 8; f++) d[28-4*f +: 4] = 4'($urandom % 6);
        end else begin
          d = $urandom;
        end
        wdata = d;
      end
      if ((it % 97) == 0) begin
        #1;
        if (!we) begin
          addr = 3'd2; #1;
          check("R8 pending readback", rdata, expect_pend_word());
        end
      end
    end
    @(negedge clk); we = 1'b0;
    idle(4);

    done = 1'b1;
    report();
  end
endmodule